// File: doc/BRIEF.md
# Address Window Decoder with Remap

This block sits on the CPU side of a system controller. It sorts each 36-bit physical address into one of a set of programmable windows: several device chip-select windows, a PCI I/O window, two PCI memory windows and one window for the controller's own register space. Software sets each window's lower bound, upper bound and relocation through a narrow register write port. For every address presented, the block returns a one-hot hit vector, the address translated for the claiming window, and a miss flag.

Ranged windows are programmed in 2 MiB blocks. A lower-bound value gives the first block and an upper-bound value gives the last block. Each window also has a relocation value that replaces bits 31:21 of the translated base. Writing a lower bound also overwrites that window's relocation value. This keeps a freshly placed window untranslated until software asks otherwise. The register-space window covers a fixed 4 KiB starting at a 2 MiB block boundary. Two fixed holes in the address map are never claimed by any window, so a window that overlaps a hole effectively ends at the hole boundary.

Top module: `addr_window_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hit_o is 0, miss_o is 1 and out_addr_o is 0. Reset leaves every ranged window disabled: lower bound 0x007F, upper bound 0, relocation 0x07F. Reset places the register-space window at block 0x00DF, which is byte address 0x1BE00000.
- R2: A write is performed when wr_en is 1. wr_idx values 0 to 6 select a ranged window, and wr_idx 7 selects the register-space window. wr_kind selects the register: 0 is the lower bound (15 bits), 1 is the upper bound (7 bits), 2 is the relocation value (11 bits), and 3 selects nothing and changes nothing. For wr_idx 7, only kind 0 has an effect. A write changes the decode only for addresses presented in later cycles.
- R3: Writing a lower bound also sets that window's relocation value to bits 10:0 of the written data.
- R4: A ranged window is enabled only when bits 6:0 of its lower bound are less than or equal to its upper bound. A disabled window claims no address.
- R5: An enabled window claims every address whose block number (address bits 35:21) lies from the lower bound up to, and including, the lower bound's bits 14:7 joined with the upper bound.
- R6: For a ranged-window hit, out_addr_o is the address minus the window base (lower bound shifted left 21), plus a relocated base. The relocated base keeps the window base's bits 35:32, takes the relocation value as bits 31:21, and has zeros below bit 21. The result wraps at 36 bits.
- R7: The register-space window claims the 4 KiB starting at its 15-bit value shifted left 21. For a hit there, out_addr_o is the offset within that 4 KiB.
- R8: No window claims an address in 0x1E000000 to 0x1F0FFFFF or in 0x1FC00000 to 0x1FCFFFFF.
- R9: When several windows claim an address, the lowest index wins: ranged windows are indices 0 to 6 and the register-space window is index 7. hit_o never has more than one bit set.
- R10: Results appear one clock after the address. On a miss, hit_o is 0, miss_o is 1 and out_addr_o equals the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Window selected by the write |
| wr_kind | input | 2 | Register selected within the window |
| wr_data | input | 15 | Write data, right aligned |
| addr_i | input | 36 | Physical address to decode |
| hit_o | output | 8 | One-hot claiming window |
| miss_o | output | 1 | No window claims the address |
| out_addr_o | output | 36 | Translated address |

## Verification
Each decode result is due on the clock edge after the one at which its address is sampled. A register write sampled on the same edge as an address still leaves that address decoded with the old settings, and it first affects the address sampled on the next edge. The bench drives inputs on the falling edge and computes each expected result from its model before applying that cycle's write to the model. It compares all three outputs at the next falling edge, so every cycle's check lands exactly one register stage behind its stimulus.

// File: rtl/awd_pkg.sv
package awd_pkg;
    typedef enum logic [1:0] {
        KIND_LOW   = 2'd0,
        KIND_HIGH  = 2'd1,
        KIND_REMAP = 2'd2,
        KIND_NONE  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
    import awd_pkg::*;
#(
    parameter int unsigned NPROG    = 7,
    parameter int unsigned LOW_W    = 15,
    parameter int unsigned HIGH_W   = 7,
    parameter int unsigned RMP_W    = 11,
    parameter int unsigned IDX_W    = 3,
    parameter logic [LOW_W-1:0] IREG_RST = 15'h00DF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [1:0]                    wr_kind,
    input  logic [LOW_W-1:0]              wr_data,
    output logic [NPROG-1:0][LOW_W-1:0]   low_o,
    output logic [NPROG-1:0][HIGH_W-1:0]  high_o,
    output logic [NPROG-1:0][RMP_W-1:0]   rmp_o,
    output logic [LOW_W-1:0]              ireg_o
);
    // Disabled at reset: low[6:0] all ones is above any 7-bit upper bound of zero
    localparam logic [LOW_W-1:0] LOW_RST = LOW_W'((1 << HIGH_W) - 1);
    localparam logic [RMP_W-1:0] RMP_RST = RMP_W'((1 << HIGH_W) - 1);

    typedef struct packed {
        logic [NPROG-1:0][LOW_W-1:0]  low;
        logic [NPROG-1:0][HIGH_W-1:0] high;
        logic [NPROG-1:0][RMP_W-1:0]  rmp;
        logic [LOW_W-1:0]             ireg;
    } regs_t;

    regs_t     regs_d, regs_q;
    reg_kind_e kind;

    assign kind = reg_kind_e'(wr_kind);

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < NPROG; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    case (kind)
                        KIND_LOW: begin
                            regs_d.low[i] = wr_data;
                            regs_d.rmp[i] = wr_data[RMP_W-1:0];
                        end
                        KIND_HIGH:  regs_d.high[i] = wr_data[HIGH_W-1:0];
                        KIND_REMAP: regs_d.rmp[i]  = wr_data[RMP_W-1:0];
                        default:    ;
                    endcase
                end
            end
            if (wr_idx == IDX_W'(NPROG) && kind == KIND_LOW) begin
                regs_d.ireg = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPROG; i++) begin
                regs_q.low[i]  <= LOW_RST;
                regs_q.high[i] <= '0;
                regs_q.rmp[i]  <= RMP_RST;
            end
            regs_q.ireg <= IREG_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign low_o  = regs_q.low;
    assign high_o = regs_q.high;
    assign rmp_o  = regs_q.rmp;
    assign ireg_o = regs_q.ireg;
endmodule

// File: rtl/awd_match.sv
module awd_match #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned GRAN_W = 21,
    parameter int unsigned HIGH_W = 7,
    parameter int unsigned RMP_W  = 11
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-GRAN_W-1:0] low,
    input  logic [HIGH_W-1:0]        high,
    input  logic [RMP_W-1:0]         rmp,
    output logic                     hit,
    output logic [ADDR_W-1:0]        out_addr
);
    localparam int unsigned LOW_W = ADDR_W - GRAN_W;

    logic [LOW_W-1:0]  blk;
    logic              enabled;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] rbase;

    assign blk     = addr[ADDR_W-1:GRAN_W];
    assign enabled = low[HIGH_W-1:0] <= high;

    // Window lives inside one 2^HIGH_W block group: compare the group, then the span
    assign hit = enabled
              && (blk[LOW_W-1:HIGH_W] == low[LOW_W-1:HIGH_W])
              && (blk[HIGH_W-1:0] >= low[HIGH_W-1:0])
              && (blk[HIGH_W-1:0] <= high);

    assign base     = {low, {GRAN_W{1'b0}}};
    assign rbase    = {low[LOW_W-1:RMP_W], rmp, {GRAN_W{1'b0}}};
    assign out_addr = addr - base + rbase;
endmodule

// File: rtl/awd_fixed.sv
module awd_fixed #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned GRAN_W = 21,
    parameter int unsigned SPAN_W = 12
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ADDR_W-GRAN_W-1:0] blk_sel,
    output logic                     hit,
    output logic [ADDR_W-1:0]        out_addr
);
    assign hit = (addr[ADDR_W-1:GRAN_W] == blk_sel)
              && (addr[GRAN_W-1:SPAN_W] == '0);
    assign out_addr = {{(ADDR_W-SPAN_W){1'b0}}, addr[SPAN_W-1:0]};
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter int unsigned ADDR_W    = 36,
    parameter int unsigned GRAN_W    = 21,
    parameter int unsigned NPROG     = 7,
    parameter int unsigned HIGH_W    = 7,
    parameter int unsigned REMAP_TOP = 32,
    parameter int unsigned SPAN_W    = 12,
    parameter logic [ADDR_W-GRAN_W-1:0] IREG_RST = 15'h00DF,
    parameter logic [ADDR_W-1:0] HOLE0_LO = 36'h0_1E00_0000,
    parameter logic [ADDR_W-1:0] HOLE0_HI = 36'h0_1F10_0000,
    parameter logic [ADDR_W-1:0] HOLE1_LO = 36'h0_1FC0_0000,
    parameter logic [ADDR_W-1:0] HOLE1_HI = 36'h0_1FD0_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(NPROG+1)-1:0]     wr_idx,
    input  logic [1:0]                     wr_kind,
    input  logic [ADDR_W-GRAN_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [NPROG:0]                 hit_o,
    output logic                           miss_o,
    output logic [ADDR_W-1:0]              out_addr_o
);
    localparam int unsigned LOW_W = ADDR_W - GRAN_W;
    localparam int unsigned RMP_W = REMAP_TOP - GRAN_W;
    localparam int unsigned NW    = NPROG + 1;
    localparam int unsigned IDX_W = $clog2(NW);

    typedef struct packed {
        logic [NW-1:0]     hit;
        logic              miss;
        logic [ADDR_W-1:0] out;
    } res_t;

    logic [NPROG-1:0][LOW_W-1:0]  low_w;
    logic [NPROG-1:0][HIGH_W-1:0] high_w;
    logic [NPROG-1:0][RMP_W-1:0]  rmp_w;
    logic [LOW_W-1:0]             ireg_w;

    logic [NW-1:0]                raw_hit;
    logic [NW-1:0][ADDR_W-1:0]    cand;
    logic                         in_hole;
    res_t                         res_d, res_q;

    awd_regs #(
        .NPROG    (NPROG),
        .LOW_W    (LOW_W),
        .HIGH_W   (HIGH_W),
        .RMP_W    (RMP_W),
        .IDX_W    (IDX_W),
        .IREG_RST (IREG_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_kind (wr_kind),
        .wr_data (wr_data),
        .low_o   (low_w),
        .high_o  (high_w),
        .rmp_o   (rmp_w),
        .ireg_o  (ireg_w)
    );

    for (genvar g = 0; g < NPROG; g++) begin : g_win
        awd_match #(
            .ADDR_W (ADDR_W),
            .GRAN_W (GRAN_W),
            .HIGH_W (HIGH_W),
            .RMP_W  (RMP_W)
        ) u_match (
            .addr     (addr_i),
            .low      (low_w[g]),
            .high     (high_w[g]),
            .rmp      (rmp_w[g]),
            .hit      (raw_hit[g]),
            .out_addr (cand[g])
        );
    end

    awd_fixed #(
        .ADDR_W (ADDR_W),
        .GRAN_W (GRAN_W),
        .SPAN_W (SPAN_W)
    ) u_ireg_win (
        .addr     (addr_i),
        .blk_sel  (ireg_w),
        .hit      (raw_hit[NPROG]),
        .out_addr (cand[NPROG])
    );

    assign in_hole = ((addr_i >= HOLE0_LO) && (addr_i < HOLE0_HI))
                  || ((addr_i >= HOLE1_LO) && (addr_i < HOLE1_HI));

    always_comb begin
        res_d.hit  = '0;
        res_d.miss = 1'b1;
        res_d.out  = addr_i;
        if (!in_hole) begin
            // Walk from the top so the lowest claiming index is written last
            for (int i = NW - 1; i >= 0; i--) begin
                if (raw_hit[i]) begin
                    res_d.hit    = '0;
                    res_d.hit[i] = 1'b1;
                    res_d.miss   = 1'b0;
                    res_d.out    = cand[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q.hit  <= '0;
            res_q.miss <= 1'b1;
            res_q.out  <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_o      = res_q.hit;
    assign miss_o     = res_q.miss;
    assign out_addr_o = res_q.out;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter int unsigned ADDR_W = 36,
    parameter int unsigned NPROG  = 7,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 15,
    parameter int unsigned RMP_W  = 11,
    parameter logic [ADDR_W-1:0] HOLE0_LO = 36'h0_1E00_0000,
    parameter logic [ADDR_W-1:0] HOLE0_HI = 36'h0_1F10_0000,
    parameter logic [ADDR_W-1:0] HOLE1_LO = 36'h0_1FC0_0000,
    parameter logic [ADDR_W-1:0] HOLE1_HI = 36'h0_1FD0_0000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [IDX_W-1:0]             wr_idx,
    input logic [1:0]                   wr_kind,
    input logic [DATA_W-1:0]            wr_data,
    input logic [ADDR_W-1:0]            addr_i,
    input logic [NPROG:0]               hit_o,
    input logic                         miss_o,
    input logic [NPROG-1:0][RMP_W-1:0]  rmp_w
);
    logic             prev_hole;
    logic             prev_low_wr;
    logic [IDX_W-1:0] prev_idx;
    logic [RMP_W-1:0] prev_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_hole   <= 1'b0;
            prev_low_wr <= 1'b0;
            prev_idx    <= '0;
            prev_val    <= '0;
        end else begin
            prev_hole   <= ((addr_i >= HOLE0_LO) && (addr_i < HOLE0_HI))
                        || ((addr_i >= HOLE1_LO) && (addr_i < HOLE1_HI));
            prev_low_wr <= wr_en && (wr_kind == 2'd0) && (wr_idx < IDX_W'(NPROG));
            prev_idx    <= wr_idx;
            prev_val    <= wr_data[RMP_W-1:0];
        end
    end

    // R1
    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (miss_o && (hit_o == '0)));

    // R9
    a_r9_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

    // R10
    a_r10_miss_clears_hit: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (hit_o == '0));

    // R8
    a_r8_hole_misses: assert property (@(posedge clk) disable iff (!rst_n)
        prev_hole |-> miss_o);

    // R3
    a_r3_low_loads_remap: assert property (@(posedge clk) disable iff (!rst_n)
        prev_low_wr |-> (rmp_w[prev_idx] == prev_val));
endmodule

bind addr_window_decoder awd_checker #(
    .ADDR_W   (ADDR_W),
    .NPROG    (NPROG),
    .IDX_W    ($clog2(NPROG+1)),
    .DATA_W   (ADDR_W-GRAN_W),
    .RMP_W    (REMAP_TOP-GRAN_W),
    .HOLE0_LO (HOLE0_LO),
    .HOLE0_HI (HOLE0_HI),
    .HOLE1_LO (HOLE1_LO),
    .HOLE1_HI (HOLE1_HI)
) u_awd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_kind (wr_kind),
    .wr_data (wr_data),
    .addr_i  (addr_i),
    .hit_o   (hit_o),
    .miss_o  (miss_o),
    .rmp_w   (rmp_w)
);

// File: tb/addr_window_decoder_bench.sv
`timescale 1ns/1ps
module addr_window_decoder_bench;
    localparam int NP = 7;
    localparam longint unsigned MASK36 = 64'hF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_kind = '0;
    logic [14:0] wr_data = '0;
    logic [35:0] addr_i = '0;
    logic [7:0]  hit_o;
    logic        miss_o;
    logic [35:0] out_addr_o;

    always #2.5 clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_kind(wr_kind), .wr_data(wr_data), .addr_i(addr_i),
        .hit_o(hit_o), .miss_o(miss_o), .out_addr_o(out_addr_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    longint unsigned m_low[NP], m_high[NP], m_rmp[NP], m_ireg;

    bit          e_vld = 1'b0;
    logic [7:0]  e_hit;
    logic        e_miss;
    logic [35:0] e_out;
    logic [35:0] e_addr;
    string       e_tag;

    function automatic void predict(input longint unsigned a);
        longint unsigned base, len, lo7, rbase;
        bool_done: begin end
        e_hit  = '0;
        e_miss = 1'b1;
        e_out  = a[35:0];
        if ((a >= 64'h1E00_0000 && a < 64'h1F10_0000) ||
            (a >= 64'h1FC0_0000 && a < 64'h1FD0_0000)) return;
        for (int w = 0; w < NP; w++) begin
            lo7 = m_low[w] & 64'h7F;
            if (lo7 <= m_high[w]) begin
                base = m_low[w] << 21;
                len  = (m_high[w] + 1 - lo7) << 21;
                if (a >= base && a < base + len) begin
                    rbase  = (base & ~(64'h7FF << 21)) | (m_rmp[w] << 21);
                    e_hit  = 8'(1) << w;
                    e_miss = 1'b0;
                    e_out  = 36'((a - base + rbase) & MASK36);
                    return;
                end
            end
        end
        base = m_ireg << 21;
        if (a >= base && a < base + 4096) begin
            e_hit  = 8'h80;
            e_miss = 1'b0;
            e_out  = 36'(a - base);
        end
    endfunction

    task automatic model_write(input int idx, input int k, input longint unsigned dat);
        if (idx < NP) begin
            if (k == 0) begin m_low[idx] = dat; m_rmp[idx] = dat & 64'h7FF; end
            else if (k == 1) m_high[idx] = dat & 64'h7F;
            else if (k == 2) m_rmp[idx] = dat & 64'h7FF;
        end else if (k == 0) begin
            m_ireg = dat;
        end
    endtask

    task automatic check_prev();
        if (e_vld) begin
            n_tests++;
            if (hit_o !== e_hit || miss_o !== e_miss || out_addr_o !== e_out) begin
                n_fail++;
                $display("FAIL %s addr=%h: actual hit=%b miss=%b out=%h expected hit=%b miss=%b out=%h",
                         e_tag, e_addr, hit_o, miss_o, out_addr_o, e_hit, e_miss, e_out);
            end
        end
    endtask

    task automatic cyc(input logic [35:0] a, input string tag, input bit we = 1'b0,
                       input int idx = 0, input int k = 0, input int dat = 0);
        @(negedge clk);
        check_prev();
        addr_i  = a;
        wr_en   = we;
        wr_idx  = 3'(idx);
        wr_kind = 2'(k);
        wr_data = 15'(dat);
        predict(64'(a));
        e_addr = a;
        e_tag  = tag;
        e_vld  = 1'b1;
        if (we) model_write(idx, k, 64'(dat));
    endtask

    task automatic wr(input int idx, input int k, input int dat, input string tag);
        cyc(36'h0, tag, 1'b1, idx, k, dat);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < NP; w++) begin
            m_low[w] = 64'h7F; m_high[w] = 0; m_rmp[w] = 64'h7F;
        end
        m_ireg = 64'hDF;
        repeat (3) @(negedge clk);
        n_tests++;
        if (hit_o !== 8'h00 || miss_o !== 1'b1 || out_addr_o !== 36'h0) begin
            n_fail++;
            $display("FAIL R1 reset: actual hit=%b miss=%b out=%h expected hit=0 miss=1 out=0",
                     hit_o, miss_o, out_addr_o);
        end
        rst_n = 1'b1;

        cyc(36'h0_0000_0000, "R1 windows off");
        cyc(36'h0_0200_0000, "R1 windows off");
        cyc(36'h0_1BE0_0000, "R7 register window base");
        cyc(36'h0_1BE0_0FFF, "R7 register window last byte");
        cyc(36'h0_1BE0_1000, "R7 past register window");

        wr(0, 0, 'h0010, "R3 low write");
        cyc(36'h0_0200_0004, "R2 write not yet visible", 1'b1, 0, 1, 'h13);
        cyc(36'h0_0200_0004, "R5 inside");
        cyc(36'h0_027F_FFFF, "R5 last block inclusive");
        cyc(36'h0_0280_0000, "R5 above");
        cyc(36'h0_01FF_FFFF, "R5 below");

        wr(0, 2, 'h100, "R6 remap write");
        cyc(36'h0_0200_0010, "R6 relocated");
        cyc(36'h0_0271_2345, "R6 relocated");

        wr(1, 0, 'h0805, "R3 low write");
        wr(1, 1, 'h06, "R5 high write");
        cyc(36'h1_00A0_0040, "R3 remap follows low");
        cyc(36'h1_00DF_FFFF, "R5 upper bits");
        cyc(36'h0_00A0_0040, "R5 upper bits differ");
        wr(1, 2, 'h7FF, "R6 remap write");
        cyc(36'h1_00A0_0040, "R6 bits above 31 kept");

        wr(2, 0, 'h20, "R4 low write");
        wr(2, 1, 'h1F, "R4 high below low");
        cyc(36'h0_0400_0000, "R4 disabled");
        wr(2, 1, 'h20, "R4 enable");
        cyc(36'h0_0400_0000, "R4 single block");
        cyc(36'h0_041F_FFFF, "R4 single block end");
        cyc(36'h0_0420_0000, "R4 past single block");

        wr(3, 0, 'h10, "R9 overlap low");
        wr(3, 1, 'h10, "R9 overlap high");
        cyc(36'h0_0200_0000, "R9 lowest index wins");
        wr(0, 1, 'h0F, "R4 disable window 0");
        cyc(36'h0_0200_0000, "R9 next window claims");
        wr(3, 3, 'h7FFF, "R2 reserved kind");
        cyc(36'h0_0200_0000, "R2 reserved kind ignored");

        wr(4, 0, 'h00E8, "R8 low write");
        wr(4, 1, 'h7F, "R8 high write");
        cyc(36'h0_1DFF_FFFF, "R8 below hole");
        cyc(36'h0_1E00_0000, "R8 hole start");
        cyc(36'h0_1F0F_FFFF, "R8 hole end");
        cyc(36'h0_1F10_0000, "R8 after hole");
        cyc(36'h0_1FBF_FFFF, "R8 between holes");
        cyc(36'h0_1FC0_0000, "R8 second hole start");
        cyc(36'h0_1FCF_FFFF, "R8 second hole end");
        cyc(36'h0_1FD0_0000, "R8 after second hole");

        wr(7, 1, 'h55, "R2 ignored kind on register window");
        cyc(36'h0_1BE0_0010, "R2 register window unchanged");
        wr(7, 0, 'h100, "R7 move register window");
        cyc(36'h0_2000_0ABC, "R7 moved");
        cyc(36'h0_1BE0_0010, "R7 old place");
        wr(7, 0, 'hF0, "R8 register window into hole");
        cyc(36'h0_1E00_0100, "R8 register window in hole");
        cyc(36'h0_0000_0000, "R10 flush");
        @(negedge clk);
        check_prev();
        finish_run();
    end
endmodule